// File: doc/BRIEF.md
# Three-Wire Timekeeping Register and Scratch-RAM Slave

This block is the device end of a three-wire synchronous serial bus: an enable line, a serial clock and one bidirectional data line, split here into an input, an output and an output enable. A host opens a frame by raising the enable, shifts in a command byte, and then either shifts data bytes in or clocks data bytes out. The command selects the timekeeping space or the scratch-RAM space, the direction, and either a single register or a burst that steps through the whole space.

The timekeeping registers are plain storage, with no counting. There are seven time bytes: seconds, minutes, hours, date, month, weekday and year. Next to them sit a control byte, whose top bit is a write-protect flag, and a trickle-charge configuration byte. The scratch RAM holds 31 bytes. Every serial edge is taken from a fast system clock, so the bus clock must be much slower than `clk`.

Top module: `tw_rtc_slave`

## Requirements
- R1: Command byte fields: bit 7 must be 1, otherwise the whole frame is ignored, with no stores and no output drive. Bit 6 = 1 selects RAM space. Bits 5:1 give the address, and 31 means burst. Bit 0 = 1 means read. Timekeeping-space addresses are 0 seconds, 1 minutes, 2 hours, 3 date, 4 month, 5 weekday, 6 year, 7 control and 8 trickle.
- R2: All bytes travel least significant bit first. Input bits are taken on rising serial-clock edges. Each read bit is put out after a falling edge. The first read bit follows the falling edge after the eighth command bit.
- R3: A single write followed by a single read of any time register or RAM byte returns the written value.
- R4: A timekeeping burst read (0xBF) returns seconds, minutes, hours, date, month, weekday, year and then control, and wraps to seconds after that.
- R5: Reset leaves control at 0x80 and all other storage at 0x00. While control bit 7 is set, writes to any register other than control are discarded. Writing control (0x8E) is always accepted.
- R6: A timekeeping burst write (0xBE) takes eight bytes: seven time bytes and then control. The time registers change only when the eighth byte completes, and a shorter frame changes nothing.
- R7: A RAM burst write (0xFE) stores 31 bytes at addresses 0 to 30 in order and ignores any bytes after that. A RAM burst read (0xFF) returns them in the same order.
- R8: Lowering the enable aborts the frame and clears the shifter, so the next frame starts fresh with a command byte.
- R9: The data output enable is high only in a read frame with the enable high, from the first falling edge after the command onward. It is low during write frames.
- R10: The trickle register (write 0x90, read 0x91) stores and returns any byte, for example 0xAB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce | input | 1 | Frame enable; high while a transfer is in progress |
| sclk | input | 1 | Serial bit clock from the host |
| sdio_in | input | 1 | Serial data from the host |
| sdio_out | output | 1 | Serial data to the host |
| sdio_oe | output | 1 | High while the slave drives the data line |

## Verification
A bit counter that is off by one shows up as rotated bytes on the very next read, so each stored value is read back through the bus right after it is written. A wrong write-protect gate or burst staging register stays hidden until the affected register is read, so each protected or partial write is followed at once by a read of the register it could have corrupted. Burst address stepping is checked across whole bursts and across the wrap, so a wrong increment or wrap limit appears as the first byte that is out of order.

// File: rtl/tw_rtc_slave.sv
module tw_rtc_slave #(
  parameter int RAM_BYTES = 31,
  parameter int TIME_REGS = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ce,
  input  logic sclk,
  input  logic sdio_in,
  output logic sdio_out,
  output logic sdio_oe
);
  localparam int RW = $clog2(RAM_BYTES);
  localparam int TW = $clog2(TIME_REGS);
  localparam logic [4:0] RAM_LAST = 5'(RAM_BYTES - 1);
  localparam logic [4:0] T_LAST   = 5'(TIME_REGS - 1);
  localparam logic [4:0] CTRL_A   = 5'(TIME_REGS);
  localparam logic [4:0] TRK_A    = 5'(TIME_REGS + 1);

  typedef enum logic [1:0] {S_CMD, S_WR, S_RD, S_IGN} st_t;

  st_t        st;
  logic       sclk_q, sdo, drv, is_ram, is_burst;
  logic [2:0] bcnt, rbit;
  logic [4:0] addr;
  logic [7:0] sr, osr, ctrl, trk, rd_byte;
  logic [7:0] tregs [TIME_REGS];
  logic [7:0] stage [TIME_REGS];
  logic [7:0] ram   [RAM_BYTES];

  wire       rise  = sclk & ~sclk_q;
  wire       fall  = ~sclk & sclk_q;
  wire       wp    = ctrl[7];
  wire [7:0] wbyte = {sdio_in, sr[7:1]};

  assign sdio_out = sdo;
  assign sdio_oe  = ce & drv & (st == S_RD);

  always_comb begin
    rd_byte = '0;
    if (is_ram) begin
      if (addr <= RAM_LAST) rd_byte = ram[addr[RW-1:0]];
    end else if (addr <= T_LAST) rd_byte = tregs[addr[TW-1:0]];
    else if (addr == CTRL_A) rd_byte = ctrl;
    else if (addr == TRK_A)  rd_byte = trk;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_CMD; sclk_q <= 1'b0; sdo <= 1'b0; drv <= 1'b0;
      is_ram <= 1'b0; is_burst <= 1'b0; bcnt <= '0; rbit <= '0; addr <= '0;
      sr <= '0; osr <= '0; ctrl <= 8'h80; trk <= '0;
      for (int i = 0; i < TIME_REGS; i++) begin tregs[i] <= '0; stage[i] <= '0; end
      for (int i = 0; i < RAM_BYTES; i++) ram[i] <= '0;
    end else begin
      sclk_q <= sclk;
      if (!ce) begin
        st <= S_CMD; bcnt <= '0; rbit <= '0; drv <= 1'b0;
      end else begin
        if (rise && st != S_RD) begin
          sr   <= wbyte;
          bcnt <= bcnt + 3'd1;
          if (bcnt == 3'd7) begin
            if (st == S_CMD) begin
              is_ram   <= wbyte[6];
              is_burst <= &wbyte[5:1];
              addr     <= (&wbyte[5:1]) ? 5'd0 : wbyte[5:1];
              st       <= !wbyte[7] ? S_IGN : (wbyte[0] ? S_RD : S_WR);
            end else if (st == S_WR) begin
              if (is_ram) begin
                if (!wp && addr <= RAM_LAST) ram[addr[RW-1:0]] <= wbyte;
                if (is_burst) begin
                  if (addr == RAM_LAST) st <= S_IGN;
                  else addr <= addr + 5'd1;
                end
              end else if (is_burst) begin
                if (addr == CTRL_A) begin
                  ctrl <= wbyte;
                  if (!wp) for (int i = 0; i < TIME_REGS; i++) tregs[i] <= stage[i];
                  st <= S_IGN;
                end else begin
                  stage[addr[TW-1:0]] <= wbyte;
                  addr <= addr + 5'd1;
                end
              end else begin
                if (addr == CTRL_A) ctrl <= wbyte;
                else if (!wp && addr == TRK_A) trk <= wbyte;
                else if (!wp && addr <= T_LAST) tregs[addr[TW-1:0]] <= wbyte;
              end
            end
          end
        end
        if (fall && st == S_RD) begin
          drv  <= 1'b1;
          rbit <= rbit + 3'd1;
          if (rbit == 3'd0) begin
            sdo <= rd_byte[0];
            osr <= rd_byte >> 1;
          end else begin
            sdo <= osr[0];
            osr <= osr >> 1;
          end
          if (rbit == 3'd7 && is_burst)
            addr <= (addr == (is_ram ? RAM_LAST : CTRL_A)) ? 5'd0 : addr + 5'd1;
        end
      end
    end
  end

  a_r5_wp_keeps_trickle: assert property (@(posedge clk) disable iff (!rst_n)
    wp |=> $stable(trk));
  a_r5_wp_keeps_seconds: assert property (@(posedge clk) disable iff (!rst_n)
    wp |=> $stable(tregs[0]));
  a_r2_out_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdo) |-> $past(fall));
  a_r8_ce_low_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |=> (st == S_CMD && bcnt == 3'd0 && !sdio_oe));
  a_r9_oe_needs_frame: assert property (@(posedge clk) disable iff (!rst_n)
    sdio_oe |-> (ce && $past(ce)));
endmodule

// File: tb/tb_tw_rtc_slave.sv
module tb_tw_rtc_slave;
  logic clk = 1'b0, rst_n = 1'b0, ce = 1'b0, sclk = 1'b0, sdi = 1'b0;
  logic sdo, oe;
  int checks = 0, errors = 0;
  logic done = 1'b0;

  tw_rtc_slave dut (.clk(clk), .rst_n(rst_n), .ce(ce), .sclk(sclk),
                    .sdio_in(sdi), .sdio_out(sdo), .sdio_oe(oe));

  always #2 clk = ~clk;

  localparam logic [15:0] VEC [10] = '{16'h8059, 16'h8230, 16'h8423, 16'h8631, 16'h8812,
                                       16'h8A07, 16'h8C99, 16'hC0C0, 16'hFCFC, 16'h90AB};

  task automatic wt(input int n); repeat (n) @(negedge clk); endtask

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic open_f(); sclk = 1'b0; ce = 1'b1; wt(2); endtask
  task automatic close_f(); ce = 1'b0; sclk = 1'b0; wt(3); endtask

  task automatic send(input logic [7:0] b);
    for (int i = 0; i < 8; i++) begin
      sdi = b[i]; sclk = 1'b0; wt(2);
      sclk = 1'b1; wt(2);
    end
  endtask

  task automatic recv(input logic exp_oe, output logic [7:0] b);
    for (int i = 0; i < 8; i++) begin
      sclk = 1'b0; wt(3);
      b[i] = sdo;
      if (i == 0) chk(exp_oe ? "R9 oe in read" : "R1 oe for invalid cmd", {7'd0, oe}, {7'd0, exp_oe});
      sclk = 1'b1; wt(2);
    end
  endtask

  task automatic wr1(input logic [7:0] cmd, input logic [7:0] d);
    open_f(); send(cmd); send(d);
    chk("R9 oe low in write", {7'd0, oe}, 8'd0);
    close_f();
  endtask

  task automatic rd1(input logic [7:0] cmd, output logic [7:0] b);
    open_f(); send(cmd); recv(1'b1, b); close_f();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] b;
    logic [7:0] bexp [8];
    wt(4); rst_n = 1'b1; wt(3);
    chk("R9 oe after reset", {7'd0, oe}, 8'd0);
    rd1(8'h8F, b); chk("R5 reset control", b, 8'h80);
    rd1(8'h81, b); chk("R3 reset seconds", b, 8'h00);

    wr1(8'h80, 8'h11); rd1(8'h81, b); chk("R5 protected seconds", b, 8'h00);
    wr1(8'h90, 8'hAB); rd1(8'h91, b); chk("R5 protected trickle", b, 8'h00);
    wr1(8'h8E, 8'h00); rd1(8'h8F, b); chk("R5 control cleared", b, 8'h00);

    foreach (VEC[i]) begin
      wr1(VEC[i][15:8], VEC[i][7:0]);
      rd1(VEC[i][15:8] | 8'h01, b);
      chk(VEC[i][15:8] == 8'h90 ? "R10 trickle" : "R3 single rw", b, VEC[i][7:0]);
    end

    open_f(); send(8'hBF);
    for (int i = 0; i < 7; i++) begin recv(1'b1, b); chk("R4 burst order", b, VEC[i][7:0]); end
    recv(1'b1, b); chk("R4 burst control", b, 8'h00);
    recv(1'b1, b); chk("R4 burst wrap", b, 8'h59);
    close_f();

    open_f(); send(8'hBE);
    for (int i = 0; i < 5; i++) send(8'h44);
    close_f();
    rd1(8'h81, b); chk("R6 partial burst no effect", b, 8'h59);
    rd1(8'h89, b); chk("R6 partial burst month", b, 8'h12);

    open_f(); send(8'h40); send(8'h77); close_f();
    rd1(8'hC1, b); chk("R1 bit7 clear ignored", b, 8'hC0);
    open_f(); send(8'h41); recv(1'b0, b); close_f();

    open_f(); send(8'hFE);
    for (int i = 0; i < 31; i++) send(8'(i * 7 + 3));
    send(8'hEE);
    close_f();
    open_f(); send(8'hFF);
    for (int i = 0; i < 31; i++) begin recv(1'b1, b); chk("R7 ram burst", b, 8'(i * 7 + 3)); end
    close_f();
    rd1(8'hC1, b); chk("R7 extra byte ignored", b, 8'h03);

    open_f();
    for (int i = 0; i < 4; i++) begin sdi = 1'b1; sclk = 1'b0; wt(2); sclk = 1'b1; wt(2); end
    close_f();
    rd1(8'h81, b); chk("R8 abort then fresh cmd", b, 8'h59);

    bexp = '{8'h05, 8'h10, 8'h08, 8'h15, 8'h06, 8'h03, 8'h24, 8'h80};
    open_f(); send(8'hBE);
    for (int i = 0; i < 8; i++) send(bexp[i]);
    chk("R9 oe low in burst write", {7'd0, oe}, 8'd0);
    close_f();
    open_f(); send(8'hBF);
    for (int i = 0; i < 8; i++) begin recv(1'b1, b); chk("R6 full burst write", b, bexp[i]); end
    close_f();
    wr1(8'h80, 8'h33); rd1(8'h81, b); chk("R5 protect after burst", b, 8'h05);
    wr1(8'hC0, 8'h55); rd1(8'hC1, b); chk("R5 protected ram", b, 8'h03);

    done = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule